// File: doc/BRIEF.md
# Pipelined Booth Mixer Multiplier

This block multiplies two signed samples, typically a converter sample and a sine or cosine value from a numerically controlled oscillator. It builds the product from an explicit datapath. The multiplier operand is recoded in radix 4 into half as many partial products as it has bits. A layered tree of 4-2 compressors and 3-2 carry-save adders reduces these to two vectors, and a final adder sums the pair. A register bank follows the recoding step, each reduction layer and the final adder, so every cycle carries at most one compressor layer of logic.

The block accepts one operand pair per cycle while `in_valid` is high. The full-width signed product appears a fixed number of cycles later, flagged by `out_valid`. The depth of the reduction tree, and with it the latency, follows from the operand width. At the default width of 18 bits there are ten rows: nine partial products plus one row that gathers the negation carries. Three reduction layers bring these to two vectors, so the latency is five cycles.

Top module: `booth_mixer_mult`

## Requirements
- R1: For every accepted pair, `out_prod` equals the signed product `in_a * in_b`, exact over the full 2·W-bit range.
- R2: `out_valid` rises exactly LATENCY cycles (5 at W=18) after the cycle in which `in_valid` was high. Each accepted pair yields exactly one valid output, and pairs may arrive on consecutive cycles.
- R3: While `rst` is high at a clock edge, `out_valid` and `out_prod` are 0 after that edge.
- R4: The extreme operands are handled exactly: −2^17·−2^17 = 2^34, (2^17−1)·(2^17−1), and −2^17·(2^17−1).
- R5: Each multiplier bit pair, with the bit below it (a 0 is appended under bit 0), selects a multiple of `in_a`: 000 and 111 select 0, 001 and 010 select +1, 011 selects +2, 100 selects −2, and 101 and 110 select −1. A negative multiple is formed by bit inversion plus a carry added at that row's lowest weight. Multiplier values that exercise every code give exact products.
- R6: Operands presented while `in_valid` is low are ignored. `out_prod` holds its last value and `out_valid` stays low.
- R7: A zero in either operand gives a zero product, including when the other operand is −2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_a | input | W (18) | Signed multiplicand |
| in_b | input | W (18) | Signed multiplier, Booth-recoded |
| out_valid | output | 1 | `out_prod` holds a new product |
| out_prod | output | 2·W (36) | Signed product, registered |

## Verification
The extreme operands are tested because they expose sign-extension and carry-truncation errors in the tree that mid-range values hide. Multiplier patterns of alternating bits and long runs of ones force every recoding code, and in particular the ±2 and negation paths. A stream of random pairs on consecutive cycles separates a correct per-stage valid pipeline from one that drops or duplicates samples. Idle cycles that present changing operands show whether the enables gate each stage.

// File: rtl/booth_mixer_pkg.sv
package booth_mixer_pkg;
  localparam int DEF_W = 18;

  function automatic int next_rows(input int n);
    int r;
    r = 2 * (n / 4);
    if ((n % 4) == 3) r = r + 2;
    else r = r + (n % 4);
    return r;
  endfunction

  function automatic int rows_at(input int n, input int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = next_rows(r);
    return r;
  endfunction

  function automatic int num_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = next_rows(r);
      c = c + 1;
    end
    return c;
  endfunction

  function automatic int mult_latency(input int w);
    return num_levels(w / 2 + 1) + 2;
  endfunction
endpackage

// File: rtl/mix_csa.sv
module mix_csa #(
  parameter int PW = 36
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  input  logic [PW-1:0] z,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  assign s = x ^ y ^ z;
  assign c = {(x[PW-2:0] & y[PW-2:0]) | (x[PW-2:0] & z[PW-2:0]) |
              (y[PW-2:0] & z[PW-2:0]), 1'b0};
endmodule

// File: rtl/mix_comp42.sv
module mix_comp42 #(
  parameter int PW = 36
) (
  input  logic [PW-1:0] r0,
  input  logic [PW-1:0] r1,
  input  logic [PW-1:0] r2,
  input  logic [PW-1:0] r3,
  output logic [PW-1:0] s,
  output logic [PW-1:0] c
);
  logic [PW-1:0] s_mid, c_mid;

  mix_csa #(.PW(PW)) u_first (.x(r0), .y(r1), .z(r2), .s(s_mid), .c(c_mid));
  mix_csa #(.PW(PW)) u_second (.x(s_mid), .y(c_mid), .z(r3), .s(s), .c(c));
endmodule

// File: rtl/mix_reduce_level.sv
module mix_reduce_level #(
  parameter int PW  = 36,
  parameter int NIN = 10,
  localparam int NQ   = NIN / 4,
  localparam int NREM = NIN % 4,
  localparam int NOUT = 2 * NQ + ((NREM == 3) ? 2 : NREM)
) (
  input  logic [NIN-1:0][PW-1:0]  din,
  output logic [NOUT-1:0][PW-1:0] dout
);
  for (genvar g = 0; g < NQ; g++) begin : g_c42
    mix_comp42 #(.PW(PW)) u_c42 (
      .r0(din[4*g]), .r1(din[4*g+1]), .r2(din[4*g+2]), .r3(din[4*g+3]),
      .s(dout[2*g]), .c(dout[2*g+1])
    );
  end

  if (NREM == 3) begin : g_tail_csa
    mix_csa #(.PW(PW)) u_csa (
      .x(din[4*NQ]), .y(din[4*NQ+1]), .z(din[4*NQ+2]),
      .s(dout[2*NQ]), .c(dout[2*NQ+1])
    );
  end else begin : g_tail_pass
    for (genvar k = 0; k < NREM; k++) begin : g_pass
      assign dout[2*NQ+k] = din[4*NQ+k];
    end
  end
endmodule

// File: rtl/mix_booth_recode.sv
module mix_booth_recode #(
  parameter int W = 18,
  localparam int NPP = W / 2,
  localparam int PW  = 2 * W
) (
  input  logic [W-1:0]          mcand,
  input  logic [W-1:0]          mplier,
  output logic [NPP:0][PW-1:0]  rows
);
  logic [W:0]      bx;
  logic [PW-1:0]   one_x, two_x;
  logic [NPP-1:0]  neg;

  assign bx    = {mplier, 1'b0};
  assign one_x = {{W{mcand[W-1]}}, mcand};
  assign two_x = {one_x[PW-2:0], 1'b0};

  for (genvar n = 0; n < NPP; n++) begin : g_pp
    logic [2:0]    grp;
    logic [PW-1:0] mag;
    assign grp = bx[2*n+2 -: 3];
    always_comb begin
      unique case (grp)
        3'b001, 3'b010: begin mag = one_x; neg[n] = 1'b0; end
        3'b011:         begin mag = two_x; neg[n] = 1'b0; end
        3'b100:         begin mag = two_x; neg[n] = 1'b1; end
        3'b101, 3'b110: begin mag = one_x; neg[n] = 1'b1; end
        default:        begin mag = '0;    neg[n] = 1'b0; end
      endcase
    end
    assign rows[n] = (neg[n] ? ~mag : mag) << (2 * n);
  end

  always_comb begin
    rows[NPP] = '0;
    for (int n = 0; n < NPP; n++) rows[NPP][2*n] = neg[n];
  end
endmodule

// File: rtl/booth_mixer_mult.sv
module booth_mixer_mult
  import booth_mixer_pkg::*;
#(
  parameter int W = DEF_W,
  localparam int NPP     = W / 2,
  localparam int NROW    = NPP + 1,
  localparam int PW      = 2 * W,
  localparam int NLEV    = num_levels(NROW),
  localparam int LATENCY = mult_latency(W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [W-1:0]  in_a,
  input  logic signed [W-1:0]  in_b,
  output logic                 out_valid,
  output logic signed [PW-1:0] out_prod
);
  logic [NROW-1:0][PW-1:0] pp_comb, pp_q;
  logic                    pp_v;

  mix_booth_recode #(.W(W)) u_recode (
    .mcand(in_a), .mplier(in_b), .rows(pp_comb)
  );

  always_ff @(posedge clk) begin
    if (in_valid) pp_q <= pp_comb;
    if (rst) pp_v <= 1'b0;
    else     pp_v <= in_valid;
  end

  for (genvar L = 0; L < NLEV; L++) begin : g_lvl
    localparam int NI = rows_at(NROW, L);
    localparam int NO = rows_at(NROW, L + 1);
    logic [NI-1:0][PW-1:0] din;
    logic [NO-1:0][PW-1:0] dcomb, q;
    logic                  vin, vq;

    if (L == 0) begin : g_src_pp
      assign din = pp_q;
      assign vin = pp_v;
    end else begin : g_src_lvl
      assign din = g_lvl[L-1].q;
      assign vin = g_lvl[L-1].vq;
    end

    mix_reduce_level #(.PW(PW), .NIN(NI)) u_level (.din(din), .dout(dcomb));

    always_ff @(posedge clk) begin
      if (vin) q <= dcomb;
      if (rst) vq <= 1'b0;
      else     vq <= vin;
    end
  end

  logic [1:0][PW-1:0] last_rows;
  logic               last_v;
  assign last_rows = g_lvl[NLEV-1].q;
  assign last_v    = g_lvl[NLEV-1].vq;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= last_v;
      if (last_v) out_prod <= $signed(last_rows[0] + last_rows[1]);
    end
  end
endmodule

// File: rtl/booth_mixer_mult_chk.sv
module booth_mixer_mult_chk #(
  parameter int W   = 18,
  parameter int LAT = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic signed [W-1:0]    in_a,
  input logic signed [W-1:0]    in_b,
  input logic                   out_valid,
  input logic signed [2*W-1:0]  out_prod
);
  logic [7:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < 8'(LAT)) since_rst <= since_rst + 8'd1;
  end

  // R2: valid follows in_valid by exactly LAT cycles
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 8'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R1: product matches signed multiplication of the accepted pair
  a_r1_product_exact: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 8'(LAT) && out_valid) |->
      (out_prod == $past(in_a, LAT) * $past(in_b, LAT)));

  // R3: reset clears the outputs
  a_r3_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_prod == '0));

  // R6: product holds when no new result is flagged
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 8'd0 && !out_valid) |-> $stable(out_prod));
endmodule

bind booth_mixer_mult booth_mixer_mult_chk #(.W(W), .LAT(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_prod(out_prod)
);

// File: tb/tb_booth_mixer_mult.sv
module tb_booth_mixer_mult;
  localparam int W   = 18;
  localparam int PW  = 2 * W;
  localparam int LAT = 5;
  localparam int NS  = 24;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [W-1:0]  in_a = '0;
  logic signed [W-1:0]  in_b = '0;
  logic                 out_valid;
  logic signed [PW-1:0] out_prod;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic signed [W-1:0] MINV = -(18'sd1 <<< (W-1));
  localparam logic signed [W-1:0] MAXV = (18'sd1 <<< (W-1)) - 18'sd1;

  always #2.5 clk = ~clk;

  booth_mixer_mult #(.W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  task automatic check(input string req, input logic signed [PW-1:0] act,
                       input logic signed [PW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [PW-1:0] ref_mul(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = a;
    eb = b;
    return ea * eb;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 out_valid after reset", PW'(out_valid), '0);
    check("R3 out_prod after reset", out_prod, '0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single(input logic signed [W-1:0] a,
                          input logic signed [W-1:0] b, input string req);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    check({req, " R2 valid low before latency"}, PW'(out_valid), '0);
    @(negedge clk);
    check({req, " R2 valid at latency"}, PW'(out_valid), PW'(1));
    check(req, out_prod, ref_mul(a, b));
  endtask

  task automatic t_extremes();
    t_single(MINV, MINV, "R4 min*min");
    t_single(MAXV, MAXV, "R4 max*max");
    t_single(MINV, MAXV, "R4 min*max");
    t_single(MAXV, MINV, "R4 max*min");
  endtask

  task automatic t_booth_codes();
    t_single(18'sd12345, 18'sh15555, "R5 alternating 01 multiplier");
    t_single(-18'sd777, 18'sh2AAAA, "R5 alternating 10 multiplier");
    t_single(18'sd1000, 18'sh0FFF0, "R5 run of ones");
    t_single(-18'sd31, 18'sh1C3C3, "R5 mixed codes");
    t_single(18'sd5, -18'sd1, "R5 all ones multiplier");
  endtask

  task automatic t_zero();
    t_single(18'sd0, MINV, "R7 zero multiplicand");
    t_single(MINV, 18'sd0, "R7 zero multiplier");
  endtask

  task automatic t_stream();
    logic signed [W-1:0] sa [NS];
    logic signed [W-1:0] sb [NS];
    for (int i = 0; i < NS; i++) begin
      sa[i] = W'($urandom);
      sb[i] = W'($urandom);
    end
    for (int k = 0; k < NS + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        check("R2 stream valid", PW'(out_valid), PW'(1));
        check("R1 stream product", out_prod, ref_mul(sa[k-LAT], sb[k-LAT]));
      end
      if (k < NS) begin
        in_a = sa[k]; in_b = sb[k]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 stream valid ends", PW'(out_valid), '0);
  endtask

  task automatic t_hold();
    logic signed [PW-1:0] kept;
    t_single(18'sd321, -18'sd654, "R1 hold setup");
    kept = out_prod;
    in_valid = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      in_a = W'($urandom);
      in_b = W'($urandom);
    end
    @(negedge clk);
    check("R6 product held", out_prod, kept);
    check("R6 valid stays low", PW'(out_valid), '0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_extremes();
    t_booth_codes();
    t_stream();
    t_hold();
    t_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule